// File: doc/BRIEF.md
# Command/Indicate Channel with Signalling Register

This block terminates the six-bit command/indicate field of a line-card time slot. In the downstream direction it filters each received command: a new value takes effect only once it has arrived unchanged in two consecutive frames. The accepted command drives the ringing, conversation and metering-timing mode enables and three general-purpose output pins. A value that appears in a single frame only is discarded.

In the upstream direction it assembles an indicate field from the live hook and ground-key detector outputs, a sticky change-summary flag and the general-purpose input pins. A small hold machine keeps every new indicate value in place for at least two frames. A six-bit signalling register tracks six line and chip status inputs. Any toggle of a bit whose mask is clear sets the summary flag. A read strobe returns the register and clears the flag. The detectors and their persistence filters sit outside the block, and their outputs arrive here as plain inputs.

Downstream filter states: `DN_EMPTY` (no frame seen since reset) moves to `DN_ARMED` on the first frame strobe. `DN_ARMED` stays in place and loads the command whenever the incoming value equals the one from the previous frame. Upstream hold states: `UP_SETTLED` (the current value has been sent for two or more frames) moves to `UP_FRESH` on a frame strobe whose candidate differs from the current value, and loads that candidate. `UP_FRESH` returns to `UP_SETTLED` on the next frame strobe without loading anything.

Top module: `cid_channel`

## Requirements
- R1: The accepted command maps bit 5 to `ring_en`, bit 4 to `conv_en`, bit 3 to `tim_en`, bit 2 to `gp_out[1]`, bit 1 to `gp_out[0]` and bit 0 to `o1_out`.
- R2: On a `frame_stb` cycle, the command loads `ci_down` only when that value equals the value sampled at the previous frame strobe. A value present in one frame only leaves the outputs unchanged.
- R3: The upstream field `ci_up` holds hook in bit 5, ground key in bit 4, the summary flag in bit 3, general I/O 1 in bit 2, general I/O 2 in bit 1 and `i1_in` in bit 0.
- R4: `ci_up` changes only at the edge of a frame strobe. After it changes, the next frame strobe leaves it unchanged, so every value is held for at least two frames.
- R5: The hook and ground-key bits of `ci_up` are taken from the live inputs, whatever the mask bits are set to.
- R6: `sum_flag` is set one cycle after any status input differs from its signalling-register bit while the mask for that bit is 0. A toggle on a masked bit (mask 1) leaves the flag unchanged.
- R7: `sig_rdata` reads hook in bit 7, ground key in bit 6, half-battery in bit 5, current limit in bit 4, over-temperature in bit 3 and clock fail in bit 2, with bits 1:0 always 0. A cycle with `sig_rd` high clears `sum_flag` at the next edge, unless an unmasked toggle occurs in that same cycle, in which case the flag stays set.
- R8: A general I/O bit whose direction bit is 1 (output) reads as 1 in `ci_up`. When the direction bit is 0 (input), the upstream bit follows `gp_in`.
- R9: Reset drives `ci_up`, the command outputs, `gp_oe` and `sig_rdata` to 0, and sets all six mask bits to 1.
- R10: `mask_we` loads `mask_wdata`, where bit 5 masks hook and bit 0 masks clock fail. `dir_we` loads `dir_wdata` into `gp_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per frame marking `ci_down` valid |
| ci_down | input | 6 | Downstream command field |
| ci_up | output | 6 | Upstream indicate field |
| ring_en | output | 1 | Ringing mode enable |
| conv_en | output | 1 | Conversation mode enable |
| tim_en | output | 1 | Metering timing enable |
| gp_out | output | 2 | General I/O output values (bit 1 = I/O 1) |
| gp_oe | output | 2 | General I/O output enables |
| gp_in | input | 2 | General I/O pin levels |
| o1_out | output | 1 | Dedicated general output |
| i1_in | input | 1 | Dedicated general input |
| hook_in | input | 1 | Off-hook detector output |
| gndk_in | input | 1 | Ground-key detector output |
| halfbat_in | input | 1 | Half-battery comparator output |
| ilim_in | input | 1 | Current-limit indication |
| otemp_in | input | 1 | Over-temperature indication |
| clkfail_in | input | 1 | Clock-fail indication |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 6 | Mask value (1 = masked) |
| dir_we | input | 1 | Direction write strobe |
| dir_wdata | input | 2 | Direction value (1 = output) |
| sig_rd | input | 1 | Signalling register read strobe |
| sig_rdata | output | 8 | Signalling register value |
| sum_flag | output | 1 | Sticky change-summary flag |

## Verification
The bound checker watches several rules on every cycle. A command change must match the values sampled at the last two frame strobes. An indicate change must fall on a frame strobe, must not follow a fresh value by only one frame, and must carry the live hook and ground-key levels. A rising summary flag must coincide with a change in the signalling register, and an output-configured I/O bit must read as 1 upstream. Other properties need a scenario to show them: a single-frame glitch being dropped, masking actually suppressing the flag, a read clearing it, and a read colliding with a toggle. The bench shows these by comparing every cycle against its behavioural model.

// File: rtl/cid_pkg.sv
package cid_pkg;
    localparam int CI_W   = 6;
    localparam int STAT_W = 6;
    localparam int SIG_W  = STAT_W + 2;
    localparam int GP_W   = 2;

    // downstream command bit positions
    localparam int DN_RING = 5;
    localparam int DN_CONV = 4;
    localparam int DN_TIM  = 3;
    localparam int DN_IO1  = 2;
    localparam int DN_IO2  = 1;
    localparam int DN_O1   = 0;

    typedef enum logic {DN_EMPTY, DN_ARMED}   dn_state_t;
    typedef enum logic {UP_SETTLED, UP_FRESH} up_state_t;
endpackage

// File: rtl/cid_dn_filter.sv
module cid_dn_filter
    import cid_pkg::*;
#(
    parameter int W = CI_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic [W-1:0] din,
    output logic [W-1:0] cmd
);
    dn_state_t    state_q, state_d;
    logic [W-1:0] last_q, last_d;
    logic [W-1:0] cmd_q, cmd_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DN_EMPTY;
            last_q  <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
            cmd_q   <= cmd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        last_d  = last_q;
        cmd_d   = cmd_q;
        unique case (state_q)
            DN_EMPTY: begin
                if (frame_stb) begin
                    last_d  = din;
                    state_d = DN_ARMED;
                end
            end
            DN_ARMED: begin
                if (frame_stb) begin
                    last_d = din;
                    if (din == last_q) cmd_d = din;
                end
            end
            default: state_d = DN_EMPTY;
        endcase
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/cid_up_hold.sv
module cid_up_hold
    import cid_pkg::*;
#(
    parameter int W = CI_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic [W-1:0] cand,
    output logic [W-1:0] up
);
    up_state_t    state_q, state_d;
    logic [W-1:0] up_q, up_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UP_SETTLED;
            up_q    <= '0;
        end else begin
            state_q <= state_d;
            up_q    <= up_d;
        end
    end

    always_comb begin
        state_d = state_q;
        up_d    = up_q;
        unique case (state_q)
            UP_SETTLED: begin
                if (frame_stb && (cand != up_q)) begin
                    up_d    = cand;
                    state_d = UP_FRESH;
                end
            end
            UP_FRESH: begin
                if (frame_stb) state_d = UP_SETTLED;
            end
            default: state_d = UP_SETTLED;
        endcase
    end

    assign up = up_q;
endmodule

// File: rtl/cid_sig_reg.sv
module cid_sig_reg
    import cid_pkg::*;
#(
    parameter int N = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         rd,
    output logic [N+1:0] rdata,
    output logic         sum
);
    logic [N-1:0] sig_q;
    logic [N-1:0] mask_q;
    logic         sum_q;
    logic [N-1:0] toggled;

    assign toggled = (stat ^ sig_q) & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q  <= '0;
            mask_q <= '1;
            sum_q  <= 1'b0;
        end else begin
            sig_q <= stat;
            if (mask_we) mask_q <= mask_wdata;
            if (|toggled)  sum_q <= 1'b1;
            else if (rd)   sum_q <= 1'b0;
        end
    end

    assign rdata = {sig_q, 2'b00};
    assign sum   = sum_q;
endmodule

// File: rtl/cid_channel.sv
module cid_channel
    import cid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [CI_W-1:0]   ci_down,
    output logic [CI_W-1:0]   ci_up,
    output logic              ring_en,
    output logic              conv_en,
    output logic              tim_en,
    output logic [GP_W-1:0]   gp_out,
    output logic [GP_W-1:0]   gp_oe,
    input  logic [GP_W-1:0]   gp_in,
    output logic              o1_out,
    input  logic              i1_in,
    input  logic              hook_in,
    input  logic              gndk_in,
    input  logic              halfbat_in,
    input  logic              ilim_in,
    input  logic              otemp_in,
    input  logic              clkfail_in,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              dir_we,
    input  logic [GP_W-1:0]   dir_wdata,
    input  logic              sig_rd,
    output logic [SIG_W-1:0]  sig_rdata,
    output logic              sum_flag
);
    logic [CI_W-1:0] cmd;
    logic [CI_W-1:0] cand;
    logic [GP_W-1:0] oe_q;
    logic [GP_W-1:0] gp_up;

    cid_dn_filter #(.W(CI_W)) u_dn (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .din(ci_down), .cmd(cmd)
    );

    assign ring_en = cmd[DN_RING];
    assign conv_en = cmd[DN_CONV];
    assign tim_en  = cmd[DN_TIM];
    assign gp_out  = {cmd[DN_IO1], cmd[DN_IO2]};
    assign o1_out  = cmd[DN_O1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      oe_q <= '0;
        else if (dir_we) oe_q <= dir_wdata;
    end
    assign gp_oe = oe_q;

    genvar g;
    generate
        for (g = 0; g < GP_W; g++) begin : g_gp
            assign gp_up[g] = oe_q[g] | gp_in[g];
        end
    endgenerate

    cid_sig_reg #(.N(STAT_W)) u_sig (
        .clk(clk), .rst_n(rst_n),
        .stat({hook_in, gndk_in, halfbat_in, ilim_in, otemp_in, clkfail_in}),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rd(sig_rd), .rdata(sig_rdata), .sum(sum_flag)
    );

    assign cand = {hook_in, gndk_in, sum_flag, gp_up, i1_in};

    cid_up_hold #(.W(CI_W)) u_up (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .cand(cand), .up(ci_up)
    );
endmodule

// File: rtl/cid_channel_chk.sv
module cid_channel_chk
    import cid_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic [CI_W-1:0]   ci_down,
    input logic [CI_W-1:0]   ci_up,
    input logic              ring_en,
    input logic              conv_en,
    input logic              tim_en,
    input logic [GP_W-1:0]   gp_out,
    input logic              o1_out,
    input logic [GP_W-1:0]   gp_oe,
    input logic              hook_in,
    input logic              gndk_in,
    input logic [SIG_W-1:0]  sig_rdata,
    input logic              sum_flag
);
    logic [CI_W-1:0] word;
    logic [CI_W-1:0] prev_frame;
    logic [1:0]      frames_held;

    assign word = {ring_en, conv_en, tim_en, gp_out, o1_out};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_frame  <= '0;
            frames_held <= 2'd1;
        end else begin
            if (frame_stb) prev_frame <= ci_down;
            if (ci_up != $past(ci_up) && $past(frame_stb)) frames_held <= 2'd0;
            else if (frame_stb && frames_held != 2'd3) frames_held <= frames_held + 2'd1;
        end
    end

    // R2
    cmd_two_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word) |-> ($past(frame_stb) && $past(ci_down) == word && $past(prev_frame) == word));

    // R4
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_up) |-> ($past(frame_stb) && $past(frames_held) >= 2'd1));

    // R5
    up_live_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_up) |-> (ci_up[5] == $past(hook_in) && ci_up[4] == $past(gndk_in)));

    // R6
    sum_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_flag) |-> (sig_rdata != $past(sig_rdata)));

    // R7
    sig_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_rdata[1:0] == 2'b00);

    // R8
    up_io_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ci_up) && $past(gp_oe[1])) |-> ci_up[2]);
endmodule

bind cid_channel cid_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ci_down(ci_down),
    .ci_up(ci_up), .ring_en(ring_en), .conv_en(conv_en), .tim_en(tim_en),
    .gp_out(gp_out), .o1_out(o1_out), .gp_oe(gp_oe), .hook_in(hook_in),
    .gndk_in(gndk_in), .sig_rdata(sig_rdata), .sum_flag(sum_flag)
);

// File: tb/sim_cid_channel.sv
`timescale 1ns/1ps
module sim_cid_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic [5:0] ci_down = '0;
    logic [5:0] ci_up;
    logic ring_en, conv_en, tim_en, o1_out, sum_flag;
    logic [1:0] gp_out, gp_oe;
    logic [1:0] gp_in = '0;
    logic i1_in = 1'b0;
    logic hook_in = 0, gndk_in = 0, halfbat_in = 0, ilim_in = 0, otemp_in = 0, clkfail_in = 0;
    logic mask_we = 0, dir_we = 0, sig_rd = 0;
    logic [5:0] mask_wdata = '0;
    logic [1:0] dir_wdata = '0;
    logic [7:0] sig_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cid_channel u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ci_down(ci_down),
        .ci_up(ci_up), .ring_en(ring_en), .conv_en(conv_en), .tim_en(tim_en),
        .gp_out(gp_out), .gp_oe(gp_oe), .gp_in(gp_in), .o1_out(o1_out),
        .i1_in(i1_in), .hook_in(hook_in), .gndk_in(gndk_in),
        .halfbat_in(halfbat_in), .ilim_in(ilim_in), .otemp_in(otemp_in),
        .clkfail_in(clkfail_in), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .dir_we(dir_we), .dir_wdata(dir_wdata), .sig_rd(sig_rd),
        .sig_rdata(sig_rdata), .sum_flag(sum_flag)
    );

    // behavioural reference model
    int  m_prev_val = -1;
    int  m_cmd = 0;
    int  m_up = 0;
    int  m_frames_since = 2;
    int  m_sig = 0;
    int  m_mask = 63;
    int  m_sum = 0;
    int  m_oe = 0;

    always @(posedge clk) begin
        int stat, cand, io1, io2, chg;
        if (!rst_n) begin
            m_prev_val = -1; m_cmd = 0; m_up = 0; m_frames_since = 2;
            m_sig = 0; m_mask = 63; m_sum = 0; m_oe = 0;
        end else begin
            stat = hook_in*32 + gndk_in*16 + halfbat_in*8 + ilim_in*4 + otemp_in*2 + clkfail_in;
            io1 = ((m_oe / 2) % 2 == 1) ? 1 : gp_in[1];
            io2 = (m_oe % 2 == 1) ? 1 : gp_in[0];
            cand = hook_in*32 + gndk_in*16 + m_sum*8 + io1*4 + io2*2 + i1_in;
            if (frame_stb) begin
                if (m_prev_val == int'(ci_down)) m_cmd = ci_down;
                m_prev_val = ci_down;
                if (m_frames_since >= 2 && cand != m_up) begin
                    m_up = cand;
                    m_frames_since = 1;
                end else begin
                    m_frames_since = m_frames_since + 1;
                end
            end
            chg = (stat ^ m_sig) & ~m_mask & 63;
            if (chg != 0) m_sum = 1;
            else if (sig_rd) m_sum = 0;
            m_sig = stat;
            if (mask_we) m_mask = mask_wdata;
            if (dir_we) m_oe = dir_wdata;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1/R2 command word", {ring_en, conv_en, tim_en, gp_out, o1_out}, m_cmd);
            check("R3/R4/R5/R8 upstream field", ci_up, m_up);
            check("R6/R7 summary flag", sum_flag, m_sum);
            check("R7 signalling register", sig_rdata, m_sig * 4);
            check("R10 direction", gp_oe, m_oe);
        end
    end

    task automatic frame(input logic [5:0] d);
        ci_down = d; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_mask(input logic [5:0] v);
        mask_wdata = v; mask_we = 1'b1;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic pulse_rd();
        sig_rd = 1'b1;
        @(negedge clk);
        sig_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state while reset is held
        check("R9 ci_up in reset", ci_up, 0);
        check("R9 gp_oe in reset", gp_oe, 0);
        check("R9 sig_rdata in reset", sig_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: a single-frame value is ignored, two matching frames load
        frame(6'h25);
        check("R2 first frame not loaded", {ring_en, conv_en, tim_en, gp_out, o1_out}, 0);
        frame(6'h12);
        check("R2 glitch value dropped", {ring_en, conv_en, tim_en, gp_out, o1_out}, 0);
        frame(6'h12);
        check("R1 conv bit", conv_en, 1);
        check("R1 gp_out bits", gp_out, 2'b01);
        frame(6'h21);
        frame(6'h21);
        check("R1 ring bit", ring_en, 1);
        check("R1 o1 bit", o1_out, 1);

        // R5: hook shows upstream while masked; R6: masked toggle leaves flag clear
        hook_in = 1'b1;
        frame(6'h21);
        check("R5 hook live while masked", ci_up, 6'b100000);
        check("R6 masked toggle ignored", sum_flag, 0);
        gndk_in = 1'b1;
        frame(6'h21);
        check("R4 held across following frame", ci_up, 6'b100000);
        frame(6'h21);
        check("R3 ground key bit", ci_up, 6'b110000);

        // R10 mask write, R6 unmasked toggle sets flag, R7 layout and read clear
        pulse_mask(6'h00);
        otemp_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 unmasked toggle sets flag", sum_flag, 1);
        check("R7 register layout", sig_rdata, 8'hC8);
        pulse_rd();
        check("R7 read clears flag", sum_flag, 0);

        // R7: read colliding with a toggle keeps the flag
        clkfail_in = 1'b1; sig_rd = 1'b1;
        @(negedge clk);
        sig_rd = 1'b0;
        check("R7 toggle wins over read", sum_flag, 1);
        pulse_rd();
        check("R7 flag cleared after second read", sum_flag, 0);

        // R10 re-mask: toggles no longer set the flag
        pulse_mask(6'h3F);
        ilim_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 mask write suppresses flag", sum_flag, 0);

        // R8: outputs read as 1 upstream
        dir_wdata = 2'b11; dir_we = 1'b1;
        @(negedge clk);
        dir_we = 1'b0;
        gp_in = 2'b00; i1_in = 1'b1;
        frame(6'h21);
        frame(6'h21);
        check("R8 output-configured bits read 1", ci_up[2:1], 2'b11);
        dir_wdata = 2'b00; dir_we = 1'b1;
        @(negedge clk);
        dir_we = 1'b0;
        gp_in = 2'b10;
        frame(6'h21);
        frame(6'h21);
        check("R8 input bits follow pins", ci_up[2:0], 3'b101);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule